// File: doc/BRIEF.md
# Vectored Interrupt Controller with Rotating Priority

This block collects 64 interrupt inputs and turns them into two request lines, a normal request (IRQ) and a fast request (FIQ). Every source owns one control byte that switches it on, chooses how its input is detected and picks where its request goes. Edge events are held in status latches until software clears them with a write of one. Level sources show their live input in the status bits.

Software reads one register to learn which IRQ source it should serve next. The search order is either fixed, where the lowest source number wins, or rotating, where the most recently reported source drops to the lowest priority. An empty search reads as 63. Software tells that case apart from a real source 63 by checking the top bit of the upper status word. Six auxiliary destinations can be selected and read back, but they drive no output.

The block sits on a simple 32-bit register bus with byte enables. Reads return data in the same cycle. Writes take effect at the clock edge.

Top module: `vec_intc`

## Requirements
- R1: After reset, every control byte, every status latch and both priority control registers read zero. Both request outputs are low and the vector register reads 63.
- R2: The control byte of source n is at byte offset 0x40+n, in byte lane n mod 4 of the word at 0x40+4*(n/4). Only lanes whose byte enable is set are written. Bits 7 and 4 of a control byte read back as zero.
- R3: Control byte bit 3 enables the source. A disabled source never raises a request output and never appears in the vector register, even while its status bit is set.
- R4: With control bits 6:5 = 00 the source is level sensitive, active high. Its status bit follows the live input, and writing one to that status bit has no effect.
- R5: Control bit 5 selects a rising edge and bit 6 a falling edge. An input edge sets the status latch at the first clock edge that samples it. The latch stays set after the input returns to its old value.
- R6: The status words are at 0x80 (sources 0-31, bit = n) and 0x84 (sources 32-63, bit = n-32). Writing one to a status bit clears the edge latch, and writing zero leaves it unchanged. An edge that arrives in the same cycle as a clear leaves the latch set.
- R7: Control bits 2:0 select the destination: 0 is IRQ, 1 is FIQ, and 2 to 7 are auxiliary destinations that raise neither output.
- R8: irq_o is high exactly while some enabled source routed to IRQ is pending. fiq_o follows the same rule for sources routed to FIQ.
- R9: A read of 0x00 returns the number of the selected pending IRQ source in bits 5:0, with all other bits zero. It returns 63 when no source is selected. Bit 31 of 0x84 shows whether source 63 is really pending.
- R10: With bit 6 of 0x20 clear (fixed priority), the lowest pending source number is selected, and reading 0x00 does not change later results.
- R11: With bit 6 of 0x20 set (rotating priority), each read of 0x00 that returns a pending source w restarts the search at w+1, wrapping from 63 to 0. The rotation start resets to 0.
- R12: The IRQ priority control register at 0x20 and the FIQ priority control register at 0x24 each hold bits 6:0 (bit 6 selects rotating priority, bits 5:0 form a priority field). Other bits read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| src_in | input | 64 | Interrupt inputs, synchronous to clk |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench attacks the idle readout of 63 against a real source 63. A design that mixes up these two cases either hides source 63 or reports a phantom request. It drives a clear in the same cycle as a falling edge, where a design with the wrong precedence loses the event. It checks that a rising edge does not set a falling-edge latch, and that a write of one to a level source's status bit has no effect. It walks the rotating search through the wrap from 63 to 0 and checks that a fixed-priority read leaves the order alone, so a pointer that moves off by one or moves in fixed mode shows up as a wrong vector.

// File: rtl/vec_intc_pkg.sv
package vec_intc_pkg;
  // register offsets (word index = byte offset >> 2)
  localparam logic [5:0] W_VECTOR   = 6'h00;
  localparam logic [5:0] W_IRQ_CTL  = 6'h08;
  localparam logic [5:0] W_FIQ_CTL  = 6'h09;
  localparam logic [5:0] W_STAT_LO  = 6'h20;
  localparam logic [5:0] W_STAT_HI  = 6'h21;
  localparam logic [1:0] CTRL_PAGE  = 2'b01;   // 0x40..0x7F

  // control byte fields
  localparam int         B_ENABLE   = 3;
  localparam int         B_RISE     = 5;
  localparam int         B_FALL     = 6;
  localparam logic [7:0] CTRL_KEEP  = 8'h6F;
  localparam logic [2:0] DEST_IRQ   = 3'd0;
  localparam logic [2:0] DEST_FIQ   = 3'd1;

  // priority control register
  localparam int         B_ROTATE   = 6;
  localparam logic [6:0] PCTL_KEEP  = 7'h7F;

  function automatic logic is_edge_mode(input logic [7:0] c);
    return c[B_RISE] | c[B_FALL];
  endfunction

  function automatic logic edge_event(input logic [7:0] c, input logic now_v,
                                      input logic was_v);
    return (c[B_RISE] & now_v & ~was_v) | (c[B_FALL] & ~now_v & was_v);
  endfunction
endpackage

// File: rtl/vec_intc_src.sv
module vec_intc_src
  import vec_intc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic       ctrl_we,
  input  logic [7:0] ctrl_wd,
  input  logic       stat_clr,
  output logic [7:0] ctrl_q,
  output logic       stat,
  output logic       want_irq,
  output logic       want_fiq
);
  logic pin_q;
  logic held;
  logic evt;

  assign evt = edge_event(ctrl_q, pin, pin_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pin_q  <= 1'b0;
      held   <= 1'b0;
    end else begin
      pin_q <= pin;
      if (ctrl_we) ctrl_q <= ctrl_wd & CTRL_KEEP;
      if (!is_edge_mode(ctrl_q)) held <= 1'b0;
      else if (evt)              held <= 1'b1;
      else if (stat_clr)         held <= 1'b0;
    end
  end

  assign stat     = is_edge_mode(ctrl_q) ? held : pin;
  assign want_irq = stat & ctrl_q[B_ENABLE] & (ctrl_q[2:0] == DEST_IRQ);
  assign want_fiq = stat & ctrl_q[B_ENABLE] & (ctrl_q[2:0] == DEST_FIQ);
endmodule

// File: rtl/vec_intc_arb.sv
module vec_intc_arb #(
  parameter int N   = 64,
  parameter int IDW = $clog2(N)
) (
  input  logic [N-1:0]   req,
  input  logic [IDW-1:0] start,
  output logic           found,
  output logic [IDW-1:0] winner
);
  // circular search from start; idle reports the top index
  always_comb begin
    logic [IDW-1:0] idx;
    found  = 1'b0;
    winner = IDW'(N - 1);
    for (int i = 0; i < N; i++) begin
      idx = start + IDW'(i);
      if (!found && req[idx]) begin
        found  = 1'b1;
        winner = idx;
      end
    end
  end
endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import vec_intc_pkg::*;
#(
  parameter int NSRC = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [3:0]  bus_be,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [63:0] src_in,
  output logic        irq_o,
  output logic        fiq_o
);
  localparam int IDW = $clog2(NSRC);

  logic [5:0]      waddr;
  logic            wr_ev, rd_ev, vec_rd;
  logic [7:0]      ctrl_q [NSRC];
  logic [NSRC-1:0] stat, irq_req, fiq_req;
  logic [6:0]      irq_ctl, fiq_ctl;
  logic [IDW-1:0]  rot_ptr, search_start, irq_winner;
  logic            irq_found, rot_en;

  assign waddr  = bus_addr[7:2];
  assign wr_ev  = bus_sel & bus_wr;
  assign rd_ev  = bus_sel & ~bus_wr;
  assign vec_rd = rd_ev & (waddr == W_VECTOR);
  assign rot_en = irq_ctl[B_ROTATE];

  for (genvar n = 0; n < NSRC; n++) begin : g_src
    logic we, clr;
    assign we  = wr_ev & (bus_addr[7:6] == CTRL_PAGE) &
                 (bus_addr[5:2] == 4'(n / 4)) & bus_be[n % 4];
    assign clr = wr_ev & (bus_addr[7:3] == 5'b10000) &
                 (bus_addr[2] == 1'(n / 32)) & bus_be[(n % 32) / 8] &
                 bus_wdata[n % 32];
    vec_intc_src u_src (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (src_in[n]),
      .ctrl_we  (we),
      .ctrl_wd  (bus_wdata[8*(n%4) +: 8]),
      .stat_clr (clr),
      .ctrl_q   (ctrl_q[n]),
      .stat     (stat[n]),
      .want_irq (irq_req[n]),
      .want_fiq (fiq_req[n])
    );
  end

  assign search_start = rot_en ? rot_ptr : '0;

  vec_intc_arb #(.N(NSRC), .IDW(IDW)) u_arb (
    .req    (irq_req),
    .start  (search_start),
    .found  (irq_found),
    .winner (irq_winner)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_ctl <= '0;
      fiq_ctl <= '0;
      rot_ptr <= '0;
    end else begin
      if (wr_ev && bus_be[0] && waddr == W_IRQ_CTL) irq_ctl <= bus_wdata[6:0] & PCTL_KEEP;
      if (wr_ev && bus_be[0] && waddr == W_FIQ_CTL) fiq_ctl <= bus_wdata[6:0] & PCTL_KEEP;
      if (vec_rd && rot_en && irq_found) rot_ptr <= irq_winner + IDW'(1);
    end
  end

  assign irq_o = |irq_req;
  assign fiq_o = |fiq_req;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[7:6] == CTRL_PAGE)
      bus_rdata = {ctrl_q[4*bus_addr[5:2]+3], ctrl_q[4*bus_addr[5:2]+2],
                   ctrl_q[4*bus_addr[5:2]+1], ctrl_q[4*bus_addr[5:2]]};
    else begin
      case (waddr)
        W_VECTOR:  bus_rdata = {{(32-IDW){1'b0}}, irq_winner};
        W_IRQ_CTL: bus_rdata = {25'd0, irq_ctl};
        W_FIQ_CTL: bus_rdata = {25'd0, fiq_ctl};
        W_STAT_LO: bus_rdata = stat[31:0];
        W_STAT_HI: bus_rdata = stat[63:32];
        default:   bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/vec_intc_chk.sv
module vec_intc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        irq_o,
  input logic        irq_found,
  input logic [5:0]  irq_winner,
  input logic [63:0] irq_req,
  input logic        vec_rd,
  input logic        rot_en,
  input logic [5:0]  rot_ptr
);
  p_out_matches_search_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == irq_found);

  p_idle_reads_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_found |-> irq_winner == 6'd63);

  p_winner_is_requesting_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_found |-> irq_req[irq_winner]);

  p_fixed_lowest_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_found && !rot_en) |-> ((irq_req & ((64'd1 << irq_winner) - 64'd1)) == 64'd0));

  p_fixed_no_move_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && !rot_en) |=> $stable(rot_ptr));

  p_rotate_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && rot_en && irq_found) |=> rot_ptr == $past(irq_winner) + 6'd1);
endmodule

bind vec_intc vec_intc_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_o      (irq_o),
  .irq_found  (irq_found),
  .irq_winner (irq_winner),
  .irq_req    (irq_req),
  .vec_rd     (vec_rd),
  .rot_en     (rot_en),
  .rot_ptr    (rot_ptr)
);

// File: tb/vec_intc_test.sv
module vec_intc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] src_in = '0;
  logic        irq_o, fiq_o;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;
  logic [31:0] rd;

  always #10 clk = ~clk;

  vec_intc uut (.*);

  // level sources, all enabled to IRQ, fixed priority
  localparam int NV = 6;
  localparam logic [63:0] TV_IN [NV] = '{
    64'h0, 64'h20, (64'd1 << 40) | 64'h80, 64'd1 << 63,
    (64'd1 << 63) | 64'd1, (64'd3 << 32)};
  localparam logic [5:0] TV_VEC [NV] = '{6'd63, 6'd5, 6'd7, 6'd63, 6'd0, 6'd32};
  localparam logic       TV_IRQ [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; src_in = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rdw(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string req);
    logic [31:0] v;
    rdw(a, v);
    check(v == e, req, v, e);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    check(irq_o == 1'b0 && fiq_o == 1'b0, "R1 outputs", {irq_o, fiq_o}, 0);
    expect_rd(8'h20, 32'h0, "R1 irq ctl");
    expect_rd(8'h24, 32'h0, "R1 fiq ctl");
    expect_rd(8'h40, 32'h0, "R1 ctrl word");
    expect_rd(8'h80, 32'h0, "R1 status lo");
    expect_rd(8'h00, 32'd63, "R1 R9 idle vector");

    // R2 byte lane write, reserved bits dropped
    wr(8'h44, 4'b0010, 32'hFFFF_FFFF);
    expect_rd(8'h44, 32'h0000_6F00, "R2 lane1 of 0x44");
    wr(8'h44, 4'b1111, 32'h0);

    // R12 priority control registers
    wr(8'h24, 4'b1111, 32'hFFFF_FFFF);
    expect_rd(8'h24, 32'h7F, "R12 fiq ctl");
    wr(8'h20, 4'b1111, 32'h0000_0025);
    expect_rd(8'h20, 32'h25, "R12 irq ctl");
    wr(8'h20, 4'b1111, 32'h0);

    // table walk: R8 R9 R10, all level enabled to IRQ
    for (int w = 0; w < 16; w++) wr(8'h40 + 8'(4 * w), 4'b1111, 32'h0808_0808);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk); src_in = TV_IN[i];
      @(negedge clk);
      check(irq_o == TV_IRQ[i], "R8 irq_o table", irq_o, TV_IRQ[i]);
      expect_rd(8'h00, {26'd0, TV_VEC[i]}, "R10 R9 vector table");
    end
    // R9 real source 63 visible in status
    @(negedge clk); src_in = 64'd1 << 63;
    expect_rd(8'h84, 32'h8000_0000, "R9 status bit31");
    // R10 fixed priority read does not rotate
    @(negedge clk); src_in = (64'd1 << 3) | (64'd1 << 9);
    expect_rd(8'h00, 32'd3, "R10 first read");
    expect_rd(8'h00, 32'd3, "R10 second read");
    // R4 level status follows input, W1C ignored
    @(negedge clk); src_in = 64'h20;
    wr(8'h80, 4'b1111, 32'h20);
    expect_rd(8'h80, 32'h20, "R4 level w1c ignored");
    @(negedge clk); src_in = 64'h0;
    expect_rd(8'h80, 32'h0, "R4 level follows input");
    // R3 disabled source
    wr(8'h44, 4'b0010, 32'h0);
    @(negedge clk); src_in = 64'h20;
    @(negedge clk);
    check(irq_o == 1'b0, "R3 masked irq_o", irq_o, 0);
    expect_rd(8'h00, 32'd63, "R3 masked vector");
    expect_rd(8'h80, 32'h20, "R3 status still shows");

    // R5 R6 edges
    do_reset();
    wr(8'h48, 4'b0100, 32'h0028_0000);          // src 10 rising, enabled, IRQ
    wr(8'h4C, 4'b0001, 32'h0000_0048);          // src 12 falling, enabled, IRQ
    @(negedge clk); src_in = (64'd1 << 10) | (64'd1 << 12);
    @(negedge clk); src_in = 64'h0 | (64'd1 << 12);
    expect_rd(8'h80, 32'h0000_0400, "R5 rise latched, fall src quiet");
    check(irq_o == 1'b1, "R8 edge irq_o", irq_o, 1);
    expect_rd(8'h00, 32'd10, "R5 vector edge");
    wr(8'h80, 4'b1111, 32'h0000_0800);
    expect_rd(8'h80, 32'h0000_0400, "R6 other bit clear no effect");
    wr(8'h80, 4'b1111, 32'h0000_0400);
    expect_rd(8'h80, 32'h0, "R6 w1c clears");
    check(irq_o == 1'b0, "R6 irq_o after clear", irq_o, 0);
    // falling edge together with a clear: event wins
    @(negedge clk);
    src_in = 64'h0;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h80; bus_be = 4'hF;
    bus_wdata = 32'h0000_1000;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    expect_rd(8'h80, 32'h0000_1000, "R6 R5 fall with clear");

    // R7 R8 destinations
    do_reset();
    wr(8'h54, 4'b0111, 32'h000F_0A09);          // 20 FIQ, 21 aux, 22 aux
    expect_rd(8'h54, 32'h000F_0A09, "R7 dest readback");
    @(negedge clk); src_in = 64'd1 << 20;
    @(negedge clk);
    check(fiq_o == 1'b1 && irq_o == 1'b0, "R7 R8 fiq route", {irq_o, fiq_o}, 2'b01);
    expect_rd(8'h00, 32'd63, "R7 fiq not in vector");
    @(negedge clk); src_in = (64'd1 << 21) | (64'd1 << 22);
    @(negedge clk);
    check(fiq_o == 1'b0 && irq_o == 1'b0, "R7 aux no output", {irq_o, fiq_o}, 0);
    expect_rd(8'h80, 32'h0060_0000, "R7 aux status");

    // R11 rotating priority
    do_reset();
    wr(8'h20, 4'b0001, 32'h40);
    wr(8'h40, 4'b1000, 32'h0800_0000);          // src 3
    wr(8'h48, 4'b0010, 32'h0000_0800);          // src 9
    wr(8'h7C, 4'b1000, 32'h0800_0000);          // src 63
    @(negedge clk); src_in = (64'd1 << 3) | (64'd1 << 9) | (64'd1 << 63);
    expect_rd(8'h00, 32'd3,  "R11 rot 1st");
    expect_rd(8'h00, 32'd9,  "R11 rot 2nd");
    expect_rd(8'h00, 32'd63, "R11 rot 3rd");
    expect_rd(8'h00, 32'd3,  "R11 rot wrap");

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule